// File: doc/BRIEF.md
# Differential Pilot Product Subsampler

This block sits behind the FFT of an OFDM receiver and watches the long training symbol as it streams past, one subcarrier per accepted sample. For every sample it multiplies the current complex value by the conjugate of the value accepted two samples earlier. Pilots sit on even subcarriers, so this product links each pilot to its neighbouring pilot. Only the products at subcarrier indices that are multiples of four, inside the two occupied pilot bands, are passed on. Each one is cut down to a short signed Q1.f word and tagged with its spectral half and its ordinal inside that half. A folded correlator downstream can then reuse one multiply-accumulate for four hypotheses, because a kept product arrives at most once every four samples.

Both sides use valid/ready streams. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or is being emptied in that same cycle (`out_ready` high). A held output stays unchanged until `out_ready` takes it. While the output is stalled, no input is accepted and the subcarrier index does not move. The output format is chosen at run time by `fmt_sel`, and it applies to the sample being accepted.

Top module: `dpp_subsampler`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted sample with `in_sos` high has subcarrier index 0. Each later accepted sample has the next index, modulo 256. The first sample after reset is index 0 even without `in_sos`.
- R3: The product for index k is conj(Y(k-2))·Y(k), where Y(k-2) is the sample accepted two samples before Y(k). In integers this is re = a·c + b·d and im = a·d − b·c, with a+jb the older sample and c+jd the current one. Inputs are Q1.15.
- R4: An output is produced for exactly the indices 4,8,…,100 and 156,160,…,252, which is 50 per full symbol. No other index produces an output.
- R5: `out_upper` is 0 for the lower band and 1 for the upper band. `out_ord` is (k−4)/4 in the lower band and (k−156)/4 in the upper band, which gives 0..24 in each.
- R6: `fmt_sel` picks the fractional bits f: 0 gives 1, 1 gives 2, 2 gives 7, 3 gives 15. The output is floor(product / 2^(30−f)), right-aligned and sign-extended in 16 bits.
- R7: A quantized value above 2^f−1 is clamped to 2^f−1, and one below −2^f is clamped to −2^f. It never wraps.
- R8: A kept product appears on the output in the cycle after its sample is accepted. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R9: `in_ready` is low exactly while a held output is not being taken. A sample that is offered but not accepted does not advance the index or the history.
- R10: At full rate, consecutive outputs within one band are exactly four clocks apart. Two kept samples are always at least four accepted samples apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Output format select (Q1.1, Q1.2, Q1.7, Q1.15) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sos | input | 1 | Sample is subcarrier 0 of a symbol |
| in_re | input | 16 | Sample real part, signed Q1.15 |
| in_im | input | 16 | Sample imaginary part, signed Q1.15 |
| out_valid | output | 1 | Kept product present |
| out_ready | input | 1 | Consumer takes the product |
| out_re | output | 16 | Quantized real part, signed, f fractional bits |
| out_im | output | 16 | Quantized imaginary part, signed, f fractional bits |
| out_upper | output | 1 | 1 = upper pilot band |
| out_ord | output | 5 | Pilot ordinal within its band |

## Verification
A kept product is due one clock after the edge that accepts its sample. If `out_ready` is low it is due later, at the handshake that takes it. The bench sets inputs just after the falling edge and reads all handshakes one nanosecond later, well before the next rising edge. It queues a prediction for every accepted sample and compares the queue against each output handshake. In the full-rate symbol it also checks that the cycle of each output is exactly one after the cycle of the accept that produced it. In the same symbol it checks that outputs within a band are four cycles apart. During a forced stall it checks on every cycle that `in_ready` is low and that the held output has not changed.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    FMT_Q1_1  = 2'd0,
    FMT_Q1_2  = 2'd1,
    FMT_Q1_7  = 2'd2,
    FMT_Q1_15 = 2'd3
  } fmt_e;

  function automatic int frac_bits(fmt_e f);
    case (f)
      FMT_Q1_1: return 1;
      FMT_Q1_2: return 2;
      FMT_Q1_7: return 7;
      default:  return 15;
    endcase
  endfunction

  function automatic bit fits_q(logic signed [15:0] v, fmt_e f);
    int lim;
    lim = 1 << frac_bits(f);
    return (int'(v) >= -lim) && (int'(v) < lim);
  endfunction
endpackage

// File: rtl/dpp_cmul3.sv
module dpp_cmul3 #(
  parameter int W = 16,
  localparam int SW = W + 2,
  localparam int MW = 2 * W + 2
) (
  input  logic signed [W-1:0]  a_re,
  input  logic signed [W-1:0]  a_im,
  input  logic signed [W-1:0]  c_re,
  input  logic signed [W-1:0]  c_im,
  output logic signed [MW-1:0] p_re,
  output logic signed [MW-1:0] p_im
);
  timeunit 1ns; timeprecision 1ps;

  // conj(a) * c computed with three real multiplies
  logic signed [SW-1:0] s_cd, s_nab, s_amb;
  logic signed [MW-1:0] k1, k2, k3;

  always_comb begin
    s_cd  = SW'(c_re) + SW'(c_im);
    s_nab = -SW'(a_im) - SW'(a_re);
    s_amb = SW'(a_re) - SW'(a_im);
    k1    = MW'(a_re) * MW'(s_cd);
    k2    = MW'(c_re) * MW'(s_nab);
    k3    = MW'(c_im) * MW'(s_amb);
    p_re  = k1 - k3;
    p_im  = k1 + k2;
  end
endmodule

// File: rtl/dpp_qsat.sv
module dpp_qsat #(
  parameter int IN_W  = 34,
  parameter int OUT_W = 16,
  parameter int BASE  = 30
) (
  input  logic signed [IN_W-1:0]  value,
  input  dpp_pkg::fmt_e           fmt,
  output logic signed [OUT_W-1:0] q
);
  timeunit 1ns; timeprecision 1ps;

  int frac;
  logic signed [IN_W-1:0] shifted, lim_pos, lim_neg, res;

  always_comb begin
    frac    = dpp_pkg::frac_bits(fmt);
    shifted = value >>> (BASE - frac);
    lim_pos = (IN_W'(1) <<< frac) - IN_W'(1);
    lim_neg = -(IN_W'(1) <<< frac);
    if (shifted > lim_pos)      res = lim_pos;
    else if (shifted < lim_neg) res = lim_neg;
    else                        res = shifted;
  end

  assign q = OUT_W'(res);
endmodule

// File: rtl/dpp_index_sel.sv
module dpp_index_sel #(
  parameter int N        = 256,
  parameter int LO_FIRST = 4,
  parameter int LO_LAST  = 100,
  parameter int HI_FIRST = 156,
  parameter int HI_LAST  = 252,
  parameter int STEP     = 4,
  localparam int IDX_W   = $clog2(N),
  localparam int LO_CNT  = (LO_LAST - LO_FIRST) / STEP + 1,
  localparam int HI_CNT  = (HI_LAST - HI_FIRST) / STEP + 1,
  localparam int ORD_W   = $clog2((LO_CNT > HI_CNT) ? LO_CNT : HI_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sos,
  output logic             sel,
  output logic             upper,
  output logic [ORD_W-1:0] ord
);
  timeunit 1ns; timeprecision 1ps;

  localparam int BND_LO [2] = '{LO_FIRST, HI_FIRST};
  localparam int BND_HI [2] = '{LO_LAST,  HI_LAST};

  logic [IDX_W-1:0] idx_q, cur;
  logic [1:0]       hit;
  logic [ORD_W-1:0] ord_h [2];

  assign cur = sos ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (fire) idx_q <= cur + IDX_W'(1);
  end

  for (genvar h = 0; h < 2; h++) begin : g_band
    int delta;
    assign hit[h] = (int'(cur) >= BND_LO[h]) && (int'(cur) <= BND_HI[h]) &&
                    ((int'(cur) % STEP) == 0);
    assign delta    = (int'(cur) - BND_LO[h]) / STEP;
    assign ord_h[h] = ORD_W'(delta);
  end

  assign sel   = |hit;
  assign upper = hit[1];
  assign ord   = hit[1] ? ord_h[1] : ord_h[0];

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(idx_q));

  // R2
  sos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && sos |=> idx_q == IDX_W'(1));
endmodule

// File: rtl/dpp_subsampler.sv
module dpp_subsampler #(
  parameter int W        = 16,
  parameter int N        = 256,
  parameter int LO_FIRST = 4,
  parameter int LO_LAST  = 100,
  parameter int HI_FIRST = 156,
  parameter int HI_LAST  = 252,
  parameter int STEP     = 4,
  parameter int OUT_W    = 16,
  localparam int MW      = 2 * W + 2,
  localparam int LO_CNT  = (LO_LAST - LO_FIRST) / STEP + 1,
  localparam int HI_CNT  = (HI_LAST - HI_FIRST) / STEP + 1,
  localparam int ORD_W   = $clog2((LO_CNT > HI_CNT) ? LO_CNT : HI_CNT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              fmt_sel,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sos,
  input  logic signed [W-1:0]     in_re,
  input  logic signed [W-1:0]     in_im,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im,
  output logic                    out_upper,
  output logic [ORD_W-1:0]        out_ord
);
  timeunit 1ns; timeprecision 1ps;

  logic                    fire, sel, upper;
  logic [ORD_W-1:0]        ord;
  logic signed [W-1:0]     h1_re, h1_im, h2_re, h2_im;
  logic signed [MW-1:0]    p_re, p_im;
  logic signed [OUT_W-1:0] q_re, q_im;
  dpp_pkg::fmt_e           fmt, fmt_q;
  logic [2:0]              gap_q;

  assign fmt      = dpp_pkg::fmt_e'(fmt_sel);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // two-deep history of accepted samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_re <= '0; h1_im <= '0; h2_re <= '0; h2_im <= '0;
    end else if (fire) begin
      h2_re <= h1_re; h2_im <= h1_im;
      h1_re <= in_re; h1_im <= in_im;
    end
  end

  dpp_index_sel #(
    .N(N), .LO_FIRST(LO_FIRST), .LO_LAST(LO_LAST),
    .HI_FIRST(HI_FIRST), .HI_LAST(HI_LAST), .STEP(STEP)
  ) u_idx (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sos(in_sos),
    .sel(sel), .upper(upper), .ord(ord)
  );

  dpp_cmul3 #(.W(W)) u_mul (
    .a_re(h2_re), .a_im(h2_im), .c_re(in_re), .c_im(in_im),
    .p_re(p_re), .p_im(p_im)
  );

  dpp_qsat #(.IN_W(MW), .OUT_W(OUT_W), .BASE(2 * W - 2)) u_q_re (
    .value(p_re), .fmt(fmt), .q(q_re)
  );

  dpp_qsat #(.IN_W(MW), .OUT_W(OUT_W), .BASE(2 * W - 2)) u_q_im (
    .value(p_im), .fmt(fmt), .q(q_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_upper <= 1'b0;
      out_ord   <= '0;
      fmt_q     <= dpp_pkg::FMT_Q1_1;
    end else if (fire && sel) begin
      out_valid <= 1'b1;
      out_re    <= q_re;
      out_im    <= q_im;
      out_upper <= upper;
      out_ord   <= ord;
      fmt_q     <= fmt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // accepted samples since the last kept one, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gap_q <= 3'd7;
    else if (fire && sel)         gap_q <= 3'd0;
    else if (fire && gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)
      && $stable(out_upper) && $stable(out_ord));

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dpp_pkg::fits_q(out_re, fmt_q) && dpp_pkg::fits_q(out_im, fmt_q));

  // R5
  ord_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_ord) < (out_upper ? HI_CNT : LO_CNT));

  // R10
  pick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && sel |-> gap_q >= 3'd3);
endmodule

// File: tb/dpp_subsampler_bench.sv
module dpp_subsampler_bench;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt_sel = 2'd3;
  logic in_valid = 1'b0, in_sos = 1'b0, out_ready = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_upper;
  logic signed [15:0] out_re, out_im;
  logic [4:0] out_ord;

  dpp_subsampler u_dpp_subsampler (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_sos(in_sos),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_upper(out_upper), .out_ord(out_ord)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  always @(posedge clk) cyc_n++;

  longint q_re[$], q_im[$];
  int q_up[$], q_ord[$], q_cyc[$];
  int m_idx = 0;
  logic signed [15:0] h1r = '0, h1i = '0, h2r = '0, h2i = '0;
  bit strict_lat = 0, in_fired = 0, done = 0;
  int out_cnt = 0, last_cyc = -1, last_up = -1, last_ord = -1;

  function automatic int fbits(logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 7;
      default: return 15;
    endcase
  endfunction

  function automatic longint quantize(longint v, int f);
    longint s, lim;
    s = v >>> (30 - f);
    lim = longint'(1) << f;
    if (s > lim - 1) s = lim - 1;
    if (s < -lim) s = -lim;
    return s;
  endfunction

  function automatic bit picked(int k);
    return (((k >= 4) && (k <= 100)) || ((k >= 156) && (k <= 252))) && (k % 4 == 0);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_accept();
    int k;
    longint pr, pi;
    k = in_sos ? 0 : m_idx;
    m_idx = (k + 1) % 256;
    if (picked(k)) begin
      pr = longint'(h2r) * longint'(in_re) + longint'(h2i) * longint'(in_im);
      pi = longint'(h2r) * longint'(in_im) - longint'(h2i) * longint'(in_re);
      q_re.push_back(quantize(pr, fbits(fmt_sel)));
      q_im.push_back(quantize(pi, fbits(fmt_sel)));
      q_up.push_back(k >= 128 ? 1 : 0);
      q_ord.push_back(k >= 128 ? (k - 156) / 4 : (k - 4) / 4);
      q_cyc.push_back(cyc_n);
    end
    h2r = h1r; h2i = h1i;
    h1r = in_re; h1i = in_im;
  endtask

  task automatic check_out();
    longint er, ei;
    int eu, eo, ec;
    if (q_re.size() == 0) begin
      check(0, "R4 output at unselected index, ordinal", out_ord, -1);
      return;
    end
    er = q_re.pop_front(); ei = q_im.pop_front();
    eu = q_up.pop_front(); eo = q_ord.pop_front(); ec = q_cyc.pop_front();
    check(out_re == er, "R3/R6/R7 real part", out_re, er);
    check(out_im == ei, "R3/R6/R7 imag part", out_im, ei);
    check(int'(out_upper) == eu, "R5 band flag", out_upper, eu);
    check(int'(out_ord) == eo, "R5 ordinal", out_ord, eo);
    if (strict_lat) begin
      check(cyc_n == ec + 1, "R8 output cycle", cyc_n, ec + 1);
      if (last_up == eu && last_ord + 1 == eo)
        check(cyc_n - last_cyc == 4, "R10 output spacing", cyc_n - last_cyc, 4);
    end
    last_cyc = cyc_n; last_up = eu; last_ord = eo;
    out_cnt++;
  endtask

  task automatic step(bit v, bit s, logic signed [15:0] r, logic signed [15:0] i, bit ordy);
    @(negedge clk);
    in_valid = v; in_sos = s; in_re = r; in_im = i; out_ready = ordy;
    #1;
    if (out_valid && out_ready) check_out();
    in_fired = in_valid && in_ready;
    if (in_fired) model_accept();
  endtask

  task automatic send(bit s, logic signed [15:0] r, logic signed [15:0] i, int pv, int pr);
    in_fired = 0;
    while (!in_fired) step(($urandom % 100) < pv, s, r, i, ($urandom % 100) < pr);
  endtask

  task automatic idle(int n);
    repeat (n) step(1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  task automatic send_symbol(int len, int pv, int pr, int mode);
    for (int k = 0; k < len; k++) begin
      logic signed [15:0] r, i;
      case (mode)
        1: begin r = (k % 8 < 4) ? 16'sd32767 : -16'sd32767; i = r; end
        2: begin r = 16'sd32767; i = -16'sd32768; end
        default: begin r = 16'($urandom); i = 16'($urandom); end
      endcase
      send(k == 0, r, i, pv, pr);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // full rate, Q1.15: latency, spacing and count (R4, R8, R10)
    fmt_sel = 2'd3; strict_lat = 1; out_cnt = 0;
    send_symbol(256, 100, 100, 0);
    idle(3);
    strict_lat = 0;
    check(out_cnt == 50, "R4 outputs per symbol", out_cnt, 50);

    // saturation in each format, both signs (R6, R7)
    for (int f = 0; f < 4; f++) begin
      fmt_sel = 2'(f);
      send_symbol(256, 100, 100, 1);
      send_symbol(256, 100, 100, 2);
    end
    idle(2);

    // stall with held output (R8, R9)
    fmt_sel = 2'd2;
    for (int k = 0; k < 4; k++) send(k == 0, 16'($urandom), 16'($urandom), 100, 100);
    step(1'b1, 1'b0, 16'sd12000, -16'sd9000, 1'b0);
    begin
      logic signed [15:0] held_re, held_im;
      step(1'b1, 1'b0, 16'sd5, 16'sd6, 1'b0);
      held_re = out_re; held_im = out_im;
      for (int c = 0; c < 5; c++) begin
        step(1'b1, 1'b0, 16'sd5, 16'sd6, 1'b0);
        check(in_ready == 1'b0, "R9 in_ready low while stalled", in_ready, 0);
        check(out_valid == 1'b1 && out_re == held_re && out_im == held_im,
              "R8 output held while stalled", out_re, held_re);
      end
    end
    for (int k = 5; k < 256; k++) send(1'b0, 16'($urandom), 16'($urandom), 100, 100);
    idle(2);

    // restart mid-symbol (R2)
    send_symbol(60, 100, 100, 0);
    send_symbol(256, 90, 100, 0);

    // random traffic and formats
    for (int s = 0; s < 20; s++) begin
      fmt_sel = 2'($urandom);
      send_symbol((s % 5 == 4) ? 100 + int'($urandom % 100) : 256, 70, 60, 0);
    end
    idle(10);
    check(q_re.size() == 0, "R4 every expected output delivered", q_re.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 run not finished actual=%0d expected=%0d", cyc_n, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule